// File: doc/BRIEF.md
# ADC Sample Timing Generator

This block derives two timing pulses from the 24 MHz converter input clock. The first is a core clock enable, which marks one input cycle out of every prescaler period. The second is a sample-start strobe, which fires once every (unit+1)*6 core clock periods. A 3-bit prescaler code selects a power-of-two divisor from 4 to 128. A core time unit value stretches the sample period. Together these fields set the sample rate: the input frequency divided by the prescaler, then divided by (unit+1)*6.

The prescaler code and the unit are loaded from a configuration write port. The load takes effect only while no conversion slot is enabled. The counters run while the global enable is high and neither power-down nor clock-down is requested. Any of these hold conditions clears both counters, so timing always restarts from a known phase. A downstream gating cell consumes the core clock enable, and the slot sequencer consumes the sample strobe.

Top module: `adc_sample_timer`

## Requirements
- R1: After reset both outputs are low, the prescaler code is 0 and the unit is 0. The first run after reset therefore gives a core enable every 4 cycles and a strobe every 24 cycles.
- R2: When running, prescaler codes 0 to 5 make `coreClkEn` pulse for one cycle every 4<<code input cycles. The first pulse comes (4<<code)-1 clock edges after the run condition rises.
- R3: Prescaler codes 6 and 7 behave exactly like code 5, giving a divisor of 128.
- R4: `sampleStrobe` pulses once every D*(unit+1)*6 input cycles, where D is the divisor. The first pulse comes D*(unit+1)*6-1 edges after the run condition rises.
- R5: `sampleStrobe` is one input cycle wide and is only high in a cycle where `coreClkEn` is high.
- R6: A configuration write (`cfgWr` high at a clock edge) is ignored while `anySlotEn` is high, and the previous prescaler and unit remain in force.
- R7: While `globalEn` is low, or `powerDown` or `clockDown` is high, both outputs are low and both counters are held at zero. When the hold is released, timing restarts from the beginning as in R2 and R4.
- R8: With prescaler code 0 and unit 1, the sample strobe period is 48 input cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter input clock (24 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Load strobe for the timing configuration |
| cfgPreCode | input | 3 | Prescaler code; divisor is 4<<min(code,5) |
| cfgUnit | input | UNIT_W (8) | Core time unit; the sample period is (unit+1)*6 core clocks |
| globalEn | input | 1 | Converter global enable |
| powerDown | input | 1 | Power-down request; holds the counters |
| clockDown | input | 1 | Clock-down request; holds the counters |
| anySlotEn | input | 1 | High while any conversion slot is enabled; freezes the configuration |
| coreClkEn | output | 1 | One-cycle core clock enable pulse |
| sampleStrobe | output | 1 | One-cycle sample-start pulse |

## Verification
The assertions assume that every input is driven to a known value from time zero and changes only between clock edges. They also assume that the configuration is not rewritten while the counters are running. Rewriting it mid-run is legal, but then the first period after the change follows neither the old nor the new setting.

The stimulus keeps to these assumptions. Every input is driven at the falling edge, and configuration writes are made only while the global enable is low. Each measurement begins from a freshly released hold, which allows first-pulse and period checks to be exact. Random prescaler codes cover the reserved values, and units are kept small so that the longest periods fit the run time.

// File: rtl/adc_timer_pkg.sv
`timescale 1ns/1ps
package adc_timer_pkg;
  // Prescaler code width and divisor range (4 << 0 .. 4 << 5)
  localparam int PRE_W      = 3;
  localparam int MAX_SHIFT  = 5;
  localparam int BASE_SHIFT = 2;
  // Core clocks per unit step of the sample period
  localparam int CORE_SLOTS = 6;

  // Strobes and selectors handed from control to datapath
  typedef struct packed {
    logic             run;       // counters advance
    logic [PRE_W-1:0] divShift;  // clamped prescaler exponent
  } timing_ctl_t;
endpackage

// File: rtl/adc_timing_ctrl.sv
`timescale 1ns/1ps
module adc_timing_ctrl
  import adc_timer_pkg::*;
#(
  parameter int UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [PRE_W-1:0]  cfgPreCode,
  input  logic [UNIT_W-1:0] cfgUnit,
  input  logic              globalEn,
  input  logic              powerDown,
  input  logic              clockDown,
  input  logic              anySlotEn,
  output timing_ctl_t       ctl,
  output logic [UNIT_W-1:0] unitVal
);
  localparam logic [PRE_W-1:0] SHIFT_CAP = PRE_W'(MAX_SHIFT);

  logic [PRE_W-1:0]  preCode;
  logic [UNIT_W-1:0] unitReg;
  logic              cfgAccept;

  // configuration only moves while every slot is idle
  assign cfgAccept = cfgWr & ~anySlotEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCode <= '0;
      unitReg <= '0;
    end else if (cfgAccept) begin
      preCode <= cfgPreCode;
      unitReg <= cfgUnit;
    end
  end

  always_comb begin
    ctl.run      = globalEn & ~powerDown & ~clockDown;
    // reserved codes fold onto the largest divisor
    ctl.divShift = (preCode > SHIFT_CAP) ? SHIFT_CAP : preCode;
  end

  assign unitVal = unitReg;

  // R6
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    anySlotEn |=> ($stable(preCode) && $stable(unitReg)));

endmodule

// File: rtl/adc_timing_datapath.sv
`timescale 1ns/1ps
module adc_timing_datapath
  import adc_timer_pkg::*;
#(
  parameter int UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  timing_ctl_t       ctl,
  input  logic [UNIT_W-1:0] unitVal,
  output logic              coreClkEn,
  output logic              sampleStrobe
);
  localparam int DIV_W = BASE_SHIFT + MAX_SHIFT;  // holds divisor-1
  localparam int PER_W = UNIT_W + 3;              // holds period-1

  logic [DIV_W-1:0] preCnt;
  logic [PER_W-1:0] sampCnt;
  logic [DIV_W:0]   divFull;
  logic [DIV_W-1:0] divLast;
  logic [PER_W-1:0] perLast;
  logic             coreTick;
  logic             sampTick;

  always_comb begin
    divFull = {{DIV_W{1'b0}}, 1'b1} << (int'(ctl.divShift) + BASE_SHIFT);
    divLast = DIV_W'(divFull - 1'b1);
    perLast = PER_W'(((PER_W+1)'(unitVal) + (PER_W+1)'(1)) * (PER_W+1)'(CORE_SLOTS)
                     - (PER_W+1)'(1));
  end

  // ">=" keeps the wrap safe if the limits shrink mid-count
  assign coreTick = ctl.run && (preCnt >= divLast);
  assign sampTick = coreTick && (sampCnt >= perLast);

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.run) begin
      preCnt <= '0;
    end else if (coreTick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.run) begin
      sampCnt <= '0;
    end else if (sampTick) begin
      sampCnt <= '0;
    end else if (coreTick) begin
      sampCnt <= sampCnt + 1'b1;
    end
  end

  assign coreClkEn    = coreTick;
  assign sampleStrobe = sampTick;

  // R5
  strobe_on_core_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> coreClkEn);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);

  // R2
  core_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn |=> !coreClkEn);

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.run) |-> (preCnt == '0 && sampCnt == '0));

endmodule

// File: rtl/adc_sample_timer.sv
`timescale 1ns/1ps
module adc_sample_timer
  import adc_timer_pkg::*;
#(
  parameter int UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [2:0]        cfgPreCode,
  input  logic [UNIT_W-1:0] cfgUnit,
  input  logic              globalEn,
  input  logic              powerDown,
  input  logic              clockDown,
  input  logic              anySlotEn,
  output logic              coreClkEn,
  output logic              sampleStrobe
);
  timing_ctl_t       ctl;
  logic [UNIT_W-1:0] unitVal;

  adc_timing_ctrl #(.UNIT_W(UNIT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWr      (cfgWr),
    .cfgPreCode (cfgPreCode),
    .cfgUnit    (cfgUnit),
    .globalEn   (globalEn),
    .powerDown  (powerDown),
    .clockDown  (clockDown),
    .anySlotEn  (anySlotEn),
    .ctl        (ctl),
    .unitVal    (unitVal)
  );

  adc_timing_datapath #(.UNIT_W(UNIT_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .unitVal      (unitVal),
    .coreClkEn    (coreClkEn),
    .sampleStrobe (sampleStrobe)
  );

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn || powerDown || clockDown) |-> (!coreClkEn && !sampleStrobe));

endmodule

// File: tb/adc_sample_timer_bench.sv
`timescale 1ns/1ps
module adc_sample_timer_bench;
  localparam int UNIT_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWr = 1'b0;
  logic [2:0]        cfgPreCode = '0;
  logic [UNIT_W-1:0] cfgUnit = '0;
  logic              globalEn = 1'b0;
  logic              powerDown = 1'b0;
  logic              clockDown = 1'b0;
  logic              anySlotEn = 1'b0;
  logic              coreClkEn;
  logic              sampleStrobe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_sample_timer #(.UNIT_W(UNIT_W)) u_adc_sample_timer (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgPreCode(cfgPreCode),
    .cfgUnit(cfgUnit), .globalEn(globalEn), .powerDown(powerDown),
    .clockDown(clockDown), .anySlotEn(anySlotEn),
    .coreClkEn(coreClkEn), .sampleStrobe(sampleStrobe)
  );

  function automatic int expDiv(int code);
    return 4 << ((code > 5) ? 5 : code);
  endfunction

  function automatic int expPer(int code, int unit);
    return expDiv(code) * (unit + 1) * 6;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic writeCfg(int code, int unit);
    @(negedge clk);
    cfgWr = 1'b1;
    cfgPreCode = 3'(code);
    cfgUnit = UNIT_W'(unit);
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  // Run condition has just risen at this negedge; counts edges from here.
  task automatic measure(int code, int unit, string req);
    int div = expDiv(code);
    int per = expPer(code, unit);
    int m = 0;
    int first = -1;
    int second = -1;
    int coreFirst = -1;
    int misalign = 0;
    int wide = 0;
    bit prevS = 1'b0;
    while (second < 0 && m < 2 * per + 8) begin
      @(posedge clk);
      @(negedge clk);
      m++;
      if (sampleStrobe) begin
        if (!coreClkEn) misalign++;
        if (prevS) wide++;
        if (first < 0) first = m;
        else second = m;
      end
      if (coreClkEn && coreFirst < 0) coreFirst = m;
      prevS = sampleStrobe;
    end
    check(coreFirst == div - 1, $sformatf("%s core first pulse code=%0d", req, code), coreFirst, div - 1);
    check(first == per - 1, $sformatf("%s first strobe code=%0d unit=%0d", req, code, unit), first, per - 1);
    check(second - first == per, $sformatf("%s strobe period code=%0d unit=%0d", req, code, unit), second - first, per);
    check(misalign == 0 && wide == 0, "R5 strobe width/alignment", misalign + wide, 0);
  endtask

  task automatic runCase(int code, int unit, string req);
    @(negedge clk);
    globalEn = 1'b1;
    measure(code, unit, req);
    globalEn = 1'b0;
  endtask

  task automatic quietWindow(string req);
    int highs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (coreClkEn || sampleStrobe) highs++;
    end
    check(highs == 0, $sformatf("%s outputs quiet while held", req), highs, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd7331);

    // R1: reset state
    globalEn = 1'b1;
    repeat (3) @(negedge clk);
    check(!coreClkEn && !sampleStrobe, "R1 outputs during reset", int'(coreClkEn) + int'(sampleStrobe), 0);
    globalEn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(!coreClkEn && !sampleStrobe, "R1 outputs after reset", int'(coreClkEn) + int'(sampleStrobe), 0);
    runCase(0, 0, "R1");

    // R8: reference setting
    writeCfg(0, 1);
    runCase(0, 1, "R8");

    // R2: each legal prescaler code
    for (int c = 0; c < 6; c++) begin
      writeCfg(c, 0);
      runCase(c, 0, "R2");
    end

    // R3: reserved codes
    writeCfg(6, 0);
    runCase(6, 0, "R3");
    writeCfg(7, 1);
    runCase(7, 1, "R3");

    // R6: write blocked while a slot is enabled
    writeCfg(7, 0);
    anySlotEn = 1'b1;
    writeCfg(2, 3);
    anySlotEn = 1'b0;
    runCase(7, 0, "R6");
    writeCfg(2, 3);
    runCase(2, 3, "R6");

    // R7: power-down, clock-down and global enable holds restart timing
    writeCfg(1, 0);
    @(negedge clk);
    globalEn = 1'b1;
    repeat (37) @(negedge clk);
    powerDown = 1'b1;
    quietWindow("R7 powerDown");
    powerDown = 1'b0;
    measure(1, 0, "R7");
    repeat (13) @(negedge clk);
    clockDown = 1'b1;
    quietWindow("R7 clockDown");
    clockDown = 1'b0;
    measure(1, 0, "R7");
    repeat (5) @(negedge clk);
    globalEn = 1'b0;
    quietWindow("R7 globalEn");
    globalEn = 1'b1;
    measure(1, 0, "R7");
    globalEn = 1'b0;

    // R4: random settings
    for (int i = 0; i < 10; i++) begin
      int c = int'($urandom_range(7, 0));
      int u = int'($urandom_range(2, 0));
      writeCfg(c, u);
      runCase(c, u, "R4");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule